// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock down to the comparison rate of a synthesizer loop's phase detector. A free-running divide-by-four stage drives a dual-modulus prescaler whose base modulus P is picked by a two-bit select. Two counters steer the prescaler through each output period. The swallow counter keeps the prescaler at P+1 for the first A of its cycles. The main counter ends the period after B prescaler cycles in total. One output pulse therefore appears every N = 4(B·P + A) input clocks.

The control is a three-state machine. PS_HOLD is entered from any state while the counter clear or power-down input is high. It leaves on release (transition "start") to PS_SWALLOW, or straight to PS_MAIN when A is zero. PS_SWALLOW moves to PS_MAIN once A prescaler cycles have run (transition "swallow done"). Both running states take the transition "reload" when the B-th prescaler cycle ends. On reload the output pulses, the counters restart and new settings are captured. The machine then goes to PS_SWALLOW, or to PS_MAIN when the new A is zero.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With legal settings, consecutive output pulses are exactly 4·(B·P + A) input clocks apart.
- R2: mod_sel selects P: 00 gives 8 (8/9), 01 gives 16, 10 gives 32, 11 gives 64.
- R3: swallow_n (A) may take any value from 0 to 63. A = 0 gives a period with no P+1 cycles, and A = B gives a period made only of P+1 cycles.
- R4: main_n (B) is legal from 3 to 8191 and must be at least A. Other values are unsupported and their behaviour is unspecified.
- R5: div_out is high for exactly one input clock per period.
- R6: While rst_n is low, or while cnt_clear is high, div_out stays low and the counters sit at their load state.
- R7: While power_down is high, the counters are held as under R6 and div_out stays low. The divide-by-four stage keeps running.
- R8: After cnt_clear or power_down is released, the first pulse arrives between N−4 and N+4 input clocks later.
- R9: New mod_sel, swallow_n or main_n values are captured only at a reload. The period in progress keeps its old length, and the next period uses the new N.
- R10: Within a period, the prescaler runs at P+1 for the first A cycles and at P for the remaining B−A cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clear | input | 1 | Synchronous counter clear; holds the counters at their load state |
| power_down | input | 1 | Power-down; holds the counters, the divide-by-four stage keeps running |
| mod_sel | input | 2 | Prescaler modulus select (P = 8 << mod_sel) |
| swallow_n | input | 6 | Swallow count A |
| main_n | input | 13 | Main count B |
| div_out | output | 1 | One-clock pulse per N input clocks |

## Verification
The bench measures the clocks between pulses for the smallest legal period (B = 3, A = 0), for A = B, for A = 63 and for the largest prescaler. A divider that lets swallow and reload collide would miscount at A = B, and one that ignores A = 0 would add a spurious P+1 cycle. Settings are changed in the middle of a period. A design that applies them at once would produce one malformed interval, and the bench catches that period. Counter clear and power-down are held over long windows to show that no pulse leaks out. The first interval after release is then bounded, which exposes a design that does not restart from its load state.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int SEL_W = 2;
    localparam int MOD_W = 7;

    typedef enum logic [1:0] {
        PS_HOLD    = 2'd0,
        PS_SWALLOW = 2'd1,
        PS_MAIN    = 2'd2
    } psd_state_e;

    function automatic logic [MOD_W-1:0] base_modulus(input logic [SEL_W-1:0] sel);
        logic [MOD_W-1:0] m;
        m = MOD_W'(8) << sel;
        return m;
    endfunction
endpackage

// File: rtl/psd_prediv.sv
module psd_prediv #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [DIV_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tick = &cnt_q;

    // R7
    prediv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int MOD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             in_tick,
    input  logic [MOD_W-1:0] modulus,
    output logic             out_tick
);
    logic [MOD_W-1:0] cnt_q;
    logic             wrap;

    assign wrap     = (cnt_q == modulus - 1'b1);
    assign out_tick = in_tick && wrap && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (hold)    cnt_q <= '0;
        else if (in_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // R10
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (cnt_q < modulus));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
    import psd_pkg::*;
#(
    parameter int A_W      = 6,
    parameter int B_W      = 13,
    parameter int PRE_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clear,
    input  logic             power_down,
    input  logic [SEL_W-1:0] mod_sel,
    input  logic [A_W-1:0]   swallow_n,
    input  logic [B_W-1:0]   main_n,
    output logic             div_out
);
    localparam int AX_W = A_W + 1;

    psd_state_e       state_q, state_d;
    logic             hold_in, q4_tick, pre_tick, pre_hold;
    logic             reload, load, last_b, last_a;
    logic [SEL_W-1:0] sel_sh;
    logic [A_W-1:0]   a_sh, a_cnt;
    logic [B_W-1:0]   b_sh, b_cnt;
    logic [MOD_W-1:0] modulus;
    psd_state_e       start_state;

    assign hold_in     = cnt_clear | power_down;
    assign pre_hold    = hold_in | (state_q == PS_HOLD);
    assign last_b      = (b_cnt == b_sh - 1'b1);
    assign last_a      = ({1'b0, a_cnt} + AX_W'(1)) == {1'b0, a_sh};
    assign start_state = (swallow_n == '0) ? PS_MAIN : PS_SWALLOW;
    assign modulus     = base_modulus(sel_sh) + MOD_W'(state_q == PS_SWALLOW);

    psd_prediv #(.DIV_LOG2(PRE_LOG2)) prediv_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (q4_tick)
    );

    psd_prescaler #(.MOD_W(MOD_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (pre_hold),
        .in_tick  (q4_tick),
        .modulus  (modulus),
        .out_tick (pre_tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        reload  = 1'b0;
        unique case (state_q)
            PS_HOLD: begin
                if (!hold_in) state_d = start_state;
            end
            PS_SWALLOW: begin
                if (pre_tick && last_b) begin
                    reload  = 1'b1;
                    state_d = start_state;
                end else if (pre_tick && last_a) begin
                    state_d = PS_MAIN;
                end
            end
            PS_MAIN: begin
                if (pre_tick && last_b) begin
                    reload  = 1'b1;
                    state_d = start_state;
                end
            end
            default: state_d = PS_HOLD;
        endcase
        if (hold_in) begin
            state_d = PS_HOLD;
            reload  = 1'b0;
        end
    end

    assign load = reload || (state_q == PS_HOLD && !hold_in);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HOLD;
        else        state_q <= state_d;
    end

    // counters, shadows and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt   <= '0;
            b_cnt   <= '0;
            a_sh    <= '0;
            b_sh    <= B_W'(3);
            sel_sh  <= '0;
            div_out <= 1'b0;
        end else begin
            div_out <= reload;
            if (hold_in) begin
                a_cnt <= '0;
                b_cnt <= '0;
            end else if (load) begin
                a_cnt  <= '0;
                b_cnt  <= '0;
                a_sh   <= swallow_n;
                b_sh   <= main_n;
                sel_sh <= mod_sel;
            end else if (pre_tick) begin
                b_cnt <= b_cnt + 1'b1;
                if (state_q == PS_SWALLOW) a_cnt <= a_cnt + 1'b1;
            end
        end
    end

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_in |=> (!div_out && b_cnt == '0 && a_cnt == '0));

    // R10
    swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SWALLOW) |-> ({1'b0, a_cnt} < {1'b0, a_sh}));

    // R4
    main_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_HOLD) |-> (b_cnt < b_sh));

    // R9
    shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PS_HOLD && !hold_in && !reload) |=>
            ($stable(b_sh) && $stable(a_sh) && $stable(sel_sh)));
endmodule

// File: tb/pulse_swallow_divider_tb_top.sv
module pulse_swallow_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_clear, power_down;
    logic [1:0]  mod_sel;
    logic [5:0]  swallow_n;
    logic [12:0] main_n;
    logic        div_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_t, last_n;
    bit done  = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_swallow_divider dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_clear(cnt_clear), .power_down(power_down),
        .mod_sel(mod_sel), .swallow_n(swallow_n), .main_n(main_n), .div_out(div_out)
    );

    function automatic int exp_n(input int sel, input int a, input int b);
        return 4 * (b * (8 << sel) + a);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 40000);
        t = cyc;
        chk(div_out == 1'b1, "R1 pulse timeout", n, 0);
        @(negedge clk);
        chk(div_out == 1'b0, "R5 width", int'(div_out), 0);
    endtask

    // change settings mid-period; old period must keep old N, next gets new N
    task automatic run_cfg(input int sel, input int a, input int b);
        int t1, t2, n_new;
        repeat (7) @(negedge clk);
        mod_sel   = 2'(sel);
        swallow_n = 6'(a);
        main_n    = 13'(b);
        n_new     = exp_n(sel, a, b);
        wait_pulse(t1);
        chk(t1 - last_t == last_n, "R9 old period kept", t1 - last_t, last_n);
        wait_pulse(t2);
        chk(t2 - t1 == n_new, "R1 R2 R3 R10 period", t2 - t1, n_new);
        last_t = t2;
        last_n = n_new;
    endtask

    task automatic hold_test(input bit use_pd, input string req);
        int pulses = 0;
        int t_rel, t;
        @(negedge clk);
        if (use_pd) power_down = 1'b1; else cnt_clear = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (div_out) pulses++;
        end
        chk(pulses == 0, req, pulses, 0);
        if (use_pd) power_down = 1'b0; else cnt_clear = 1'b0;
        t_rel = cyc;
        wait_pulse(t);
        chk((t - t_rel >= last_n - 4) && (t - t_rel <= last_n + 4),
            "R8 first pulse after release", t - t_rel, last_n);
        last_t = t;
    endtask

    initial begin
        rst_n = 1'b0; cnt_clear = 1'b0; power_down = 1'b0;
        mod_sel = 2'd0; swallow_n = 6'd0; main_n = 13'd3;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(div_out == 1'b0, "R6 reset state", int'(div_out), 0);
        rst_n = 1'b1;
        wait_pulse(last_t);
        last_n = exp_n(0, 0, 3);

        // directed corners
        run_cfg(0, 0, 3);    // R4 smallest legal B, R3 A=0
        run_cfg(0, 5, 5);    // R3 A=B
        run_cfg(3, 3, 3);    // R2 largest prescaler
        run_cfg(1, 0, 10);
        run_cfg(0, 63, 63);  // R3 maximum A
        run_cfg(2, 17, 40);
        run_cfg(3, 0, 3);

        // R6 / R7 holds
        hold_test(1'b0, "R6 clear quiet");
        run_cfg(3, 0, 3);
        run_cfg(1, 7, 12);
        hold_test(1'b1, "R7 power-down quiet");
        run_cfg(1, 7, 12);

        // constrained random
        for (int i = 0; i < 8; i++) begin
            int s, a, b;
            s = int'($urandom % 4);
            a = int'($urandom % 16);
            b = ((a > 3) ? a : 3) + int'($urandom % 20);
            run_cfg(s, a, b);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule